// File: doc/BRIEF.md
# Gated Clock Frequency Counter

This block measures how fast one of many candidate clocks runs. Software picks a source, programs a gate length in microseconds and starts a measurement through a small 32-bit register bus. The block then counts the rising edges of the chosen clock over a window of whole microsecond ticks. The tick is a one-cycle pulse in the system clock domain. When the window closes, the count is stored in a read-only result word. Software turns the count into hertz.

Each candidate clock drives its own toggle flop. The toggle of the selected source passes through a two-stage synchroniser into the system domain. There every change of the toggle counts as one edge. Any measured clock must therefore run below half the system clock. The counter saturates instead of wrapping, so an all-ones result means the reading is not valid. A continuous mode restarts the window with no gap. An optional interrupt gives a one-cycle pulse at each window end.

Register words sit on a 4-byte stride: 0x0 is an unused duty word, 0x4 is control/status, 0x8 is reserved and 0xC holds the result.

Top module: `clk_freq_meter`

## Requirements
- R1: Reads of byte offsets 0x0 and 0x8 always return zero. Offset 0xC returns the last stored count in its low CNT_W bits, with zeros above. All four words read zero after reset.
- R2: The control word at 0x4 has these fields: gate length minus one in bits [15:0], enable in bit 16, continuous mode in bit 17, interrupt enable in bit 18, run in bit 19 and source select in bits [26:20]. The word reads back as last written. Bit 31 reads the busy flag.
- R3: A write to 0x4 with both enable (bit 16) and run (bit 19) at 1 starts a measurement. Busy reads 1 from the cycle after that write.
- R4: After a start, the window opens on the next reference tick and lasts exactly (gate field + 1) ticks. The result is the number of rising edges of the selected clock inside the window, within ±2. In single-shot mode busy returns to 0 when the window ends.
- R5: The source select value N picks input bit N of the candidate clock bus. A source that does not toggle measures zero.
- R6: The edge count saturates at all-ones (2^CNT_W − 1) and never wraps.
- R7: The result word keeps its value until the next window completes. An aborted measurement leaves it unchanged.
- R8: A write to 0x4 with enable at 0 aborts any measurement. Busy reads 0 from the next cycle, and the whole control word takes the written value, so writing zero clears it.
- R9: With continuous mode set, a new window starts at the tick that closes the previous one. The result updates after every window and busy stays 1. After continuous mode is cleared, the running window completes and the block goes idle.
- R10: With interrupt enable set, the irq output pulses high for one cycle at the end of every window, in the same cycle the result updates. With it clear, irq stays low.
- R11: Writes to the select field during a measurement do not change the source being counted until the next start.
- R12: A write to 0x4 with enable at 1 and run at 0 does not start a measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register word |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_us | input | 1 | One-cycle reference pulse, once per microsecond |
| meas_clk | input | NUM_SRC | Candidate clocks to measure |
| irq | output | 1 | One-cycle end-of-window pulse |

## Verification
The hardest situation to reach is a change of the select field while a window is open. The only visible evidence is that the count still follows the old source. The bench starts a window on one clock and then rewrites the control word with a different select, enable held high and run low. The two clocks run at rates far apart, so the final count shows which one was sampled. Saturation would take far too long at 16 bits. It is reached through a second instance built with a 10-bit counter, fed by the fastest legal source over a long gate.

// File: rtl/clk_meter_pkg.sv
package clk_meter_pkg;
  // control word field positions (software-visible layout)
  localparam int DUR_LSB   = 0;
  localparam int DUR_W     = 16;
  localparam int EN_BIT    = 16;
  localparam int CONT_BIT  = 17;
  localparam int IE_BIT    = 18;
  localparam int RUN_BIT   = 19;
  localparam int SEL_LSB   = 20;
  localparam int BUSY_BIT  = 31;

  // word index = byte address / 4
  localparam logic [1:0] WORD_DUTY   = 2'd0;
  localparam logic [1:0] WORD_CTRL   = 2'd1;
  localparam logic [1:0] WORD_RSVD   = 2'd2;
  localparam logic [1:0] WORD_RESULT = 2'd3;

  typedef enum logic [1:0] {
    GATE_IDLE = 2'd0,
    GATE_ARM  = 2'd1,
    GATE_OPEN = 2'd2
  } gate_state_e;
endpackage

// File: rtl/src_edge_capture.sv
module src_edge_capture #(
  parameter int NUM_SRC = 128,
  parameter int SEL_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] meas_clk_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               edge_o
);
  logic [NUM_SRC-1:0] tog;

  // one toggle flop per candidate clock, in that clock's own domain
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_tog
    logic t_q;
    always_ff @(posedge meas_clk_i[g] or negedge rst_n) begin
      if (!rst_n) t_q <= 1'b0;
      else        t_q <= ~t_q;
    end
    assign tog[g] = t_q;
  end

  logic sel_tog;
  always_comb begin
    sel_tog = 1'b0;
    if (int'(sel_i) < NUM_SRC) sel_tog = tog[sel_i];
  end

  // two-stage synchroniser plus history flop
  logic sync1_q, sync2_q, hist_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      hist_q  <= 1'b0;
    end else begin
      sync1_q <= sel_tog;
      sync2_q <= sync1_q;
      hist_q  <= sync2_q;
    end
  end

  // every toggle change stands for one rising edge of the source
  assign edge_o = sync2_q ^ hist_q;
endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer
  import clk_meter_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [DW-1:0] dur_i,
  input  logic          cont_i,
  input  logic          tick_i,
  output logic          busy_o,
  output logic          open_o,
  output logic          restart_o,
  output logic          close_o
);
  gate_state_e state_q, state_d;
  logic [DW-1:0] dur_q, tcnt_q, tcnt_d;
  logic last_tick;

  assign last_tick = (state_q == GATE_OPEN) && tick_i && (tcnt_q == dur_q);
  assign close_o   = last_tick && !abort_i && !start_i;
  assign restart_o = !abort_i && !start_i &&
                     (((state_q == GATE_ARM) && tick_i) || (last_tick && cont_i));
  assign busy_o    = (state_q != GATE_IDLE);
  assign open_o    = (state_q == GATE_OPEN);

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    if (abort_i) begin
      state_d = GATE_IDLE;
    end else if (start_i) begin
      state_d = GATE_ARM;
      tcnt_d  = '0;
    end else begin
      unique case (state_q)
        GATE_ARM: if (tick_i) begin
          state_d = GATE_OPEN;
          tcnt_d  = '0;
        end
        GATE_OPEN: if (tick_i) begin
          if (tcnt_q == dur_q) begin
            state_d = cont_i ? GATE_OPEN : GATE_IDLE;
            tcnt_d  = '0;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GATE_IDLE;
      tcnt_q  <= '0;
      dur_q   <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      if (start_i) dur_q <= dur_i;
    end
  end

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);

  assert_single_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (close_o && !cont_i) |=> !busy_o);

  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_o && !open_o));
endmodule

// File: rtl/sat_edge_counter.sv
module sat_edge_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic          done_i,
  output logic [CW-1:0] result_o
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt_q, cnt_nxt;

  always_comb begin
    if (cnt_q == CMAX) cnt_nxt = CMAX;
    else               cnt_nxt = cnt_q + {{(CW-1){1'b0}}, inc_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      result_o <= '0;
    end else begin
      cnt_q <= clr_i ? '0 : cnt_nxt;
      if (done_i) result_o <= cnt_nxt;
    end
  end

  assert_sat_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == CMAX) && !clr_i) |=> (cnt_q == CMAX));

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> $stable(result_o));
endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter
  import clk_meter_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         bus_addr,
  input  logic               bus_wen,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               tick_us,
  input  logic [NUM_SRC-1:0] meas_clk,
  output logic               irq
);
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [1:0] word;
  assign word = bus_addr[3:2];

  logic unused_bus_bits;
  assign unused_bus_bits = ^{bus_addr[1:0], bus_wdata[BUSY_BIT]};

  // stored control word; bit 31 is the live busy flag instead
  logic [30:0] ctrl_q;
  logic [SEL_W-1:0] active_sel_q;
  logic ctrl_wr, start, abort;

  assign ctrl_wr = bus_wen && (word == WORD_CTRL);
  assign start   = ctrl_wr && bus_wdata[EN_BIT] && bus_wdata[RUN_BIT];
  assign abort   = ctrl_wr && !bus_wdata[EN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q       <= '0;
      active_sel_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata[30:0];
      if (start)   active_sel_q <= bus_wdata[SEL_LSB +: SEL_W];
    end
  end

  logic edge_seen, busy, win_open, win_restart, win_close;
  logic [CNT_W-1:0] result;

  src_edge_capture #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .meas_clk_i (meas_clk),
    .sel_i      (active_sel_q),
    .edge_o     (edge_seen)
  );

  gate_sequencer #(.DW(DUR_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .abort_i   (abort),
    .dur_i     (bus_wdata[DUR_LSB +: DUR_W]),
    .cont_i    (ctrl_q[CONT_BIT]),
    .tick_i    (tick_us),
    .busy_o    (busy),
    .open_o    (win_open),
    .restart_o (win_restart),
    .close_o   (win_close)
  );

  sat_edge_counter #(.CW(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (win_restart),
    .inc_i    (win_open && edge_seen),
    .done_i   (win_close),
    .result_o (result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= win_close && ctrl_q[IE_BIT];
  end

  always_comb begin
    bus_rdata = '0;
    unique case (word)
      WORD_CTRL:   bus_rdata = {busy, ctrl_q};
      WORD_RESULT: bus_rdata[CNT_W-1:0] = result;
      default:     bus_rdata = '0;
    endcase
  end

  assert_sel_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> $stable(active_sel_q));

  assert_irq_after_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(busy));

  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !irq);
endmodule

// File: tb/test_clk_freq_meter.sv
`timescale 1ns/1ps
module test_clk_freq_meter;
  localparam int NSRC = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic        bus_wen_n = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, rdata_n;
  logic        tick_us = 1'b0;
  logic        irq, irq_n;
  logic        s_a = 1'b0, s_b = 1'b0, s_c = 1'b0;
  logic [NSRC-1:0] srcs;

  // bit 127 = 50 MHz, bit 5 = 10 MHz, bit 0 = 25 MHz, all others static
  assign srcs = {s_c, 121'b0, s_b, 4'b0, s_a};

  int checks = 0;
  int fails  = 0;
  int irq_cnt = 0;
  int irq_run = 0;
  int irq_max_run = 0;

  clk_freq_meter i_clk_freq_meter (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_us(tick_us),
    .meas_clk(srcs), .irq(irq)
  );

  clk_freq_meter #(.NUM_SRC(NSRC), .CNT_W(10)) i_clk_freq_meter_narrow (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen_n),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_n), .tick_us(tick_us),
    .meas_clk(srcs), .irq(irq_n)
  );

  initial forever #4 clk = ~clk;
  initial forever #20 s_a = ~s_a;
  initial forever #50 s_b = ~s_b;
  initial forever #10 s_c = ~s_c;

  // 1 us tick: one cycle every 125 system cycles
  initial begin
    forever begin
      repeat (124) @(negedge clk);
      tick_us = 1'b1;
      @(negedge clk);
      tick_us = 1'b0;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (irq) begin
        irq_cnt++;
        irq_run++;
        if (irq_run > irq_max_run) irq_max_run = irq_run;
      end else begin
        irq_run = 0;
      end
    end
  end

  function automatic logic [31:0] cw(input int dur, input bit en, input bit cont,
                                     input bit ie, input bit run, input int sel);
    logic [31:0] v;
    v = '0;
    v[15:0]  = dur[15:0];
    v[16]    = en;
    v[17]    = cont;
    v[18]    = ie;
    v[19]    = run;
    v[26:20] = sel[6:0];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit narrow = 0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d;
    if (narrow) bus_wen_n = 1'b1; else bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0; bus_wen_n = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, input bit narrow = 0);
    bus_addr = a;
    #1;
    d = narrow ? rdata_n : bus_rdata;
  endtask

  task automatic wait_idle(output int cyc, input bit narrow = 0);
    logic [31:0] v;
    cyc = 0;
    for (int i = 0; i < 20000; i++) begin
      rd(4'h4, v, narrow);
      if (!v[31]) break;
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), v);
      chk(v == 0, "R1 reset read", v, 0);
    end
  endtask

  task automatic t_single;
    logic [31:0] v;
    int cyc;
    wr(4'h4, cw(3, 1, 0, 0, 1, 0));
    rd(4'h4, v);
    chk(v[31] == 1'b1, "R3 busy after start", v[31], 1);
    wait_idle(cyc);
    chk(cyc >= 499 && cyc <= 627, "R4 busy length cycles", cyc, 560);
    rd(4'hC, v);
    chk(v >= 98 && v <= 102, "R4 count 25MHz over 4us", v, 100);
    rd(4'h4, v);
    chk(v == cw(3, 1, 0, 0, 1, 0), "R2 control readback", v, cw(3, 1, 0, 0, 1, 0));
    rd(4'h0, v);
    chk(v == 0, "R1 duty word zero", v, 0);
    rd(4'h8, v);
    chk(v == 0, "R1 reserved word zero", v, 0);
    chk(irq_cnt == 0, "R10 no irq when disabled", irq_cnt, 0);
  endtask

  task automatic t_select;
    logic [31:0] v;
    int cyc;
    wr(4'h4, cw(4, 1, 0, 0, 1, 5));
    wait_idle(cyc);
    rd(4'hC, v);
    chk(v >= 48 && v <= 52, "R5 source 5 over 5us", v, 50);
    wr(4'h4, cw(1, 1, 0, 0, 1, 64));
    wait_idle(cyc);
    rd(4'hC, v);
    chk(v == 0, "R5 static source", v, 0);
  endtask

  task automatic t_no_run;
    logic [31:0] v;
    wr(4'h4, cw(1, 1, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
    rd(4'h4, v);
    chk(v[31] == 1'b0, "R12 run low no start", v[31], 0);
    rd(4'hC, v);
    chk(v == 0, "R12 result untouched", v, 0);
  endtask

  task automatic t_sel_change;
    logic [31:0] v;
    int cyc;
    wr(4'h4, cw(3, 1, 0, 0, 1, 0));
    repeat (200) @(negedge clk);
    wr(4'h4, cw(3, 1, 0, 0, 0, 5));
    wait_idle(cyc);
    rd(4'hC, v);
    chk(v >= 98 && v <= 102, "R11 select change ignored", v, 100);
  endtask

  task automatic t_abort;
    logic [31:0] v, prev;
    rd(4'hC, prev);
    wr(4'h4, cw(99, 1, 0, 1, 1, 5));
    repeat (300) @(negedge clk);
    wr(4'h4, 32'h0);
    rd(4'h4, v);
    chk(v == 0, "R8 abort clears control and busy", v, 0);
    repeat (200) @(negedge clk);
    rd(4'hC, v);
    chk(v == prev, "R7 result kept on abort", v, prev);
    chk(irq_cnt == 0, "R10 no irq on abort", irq_cnt, 0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    int cyc;
    wr(4'h4, cw(0, 1, 0, 1, 1, 5));
    wait_idle(cyc);
    repeat (2) @(negedge clk);
    rd(4'hC, v);
    chk(v >= 8 && v <= 12, "R4 one-tick window", v, 10);
    chk(irq_cnt == 1, "R10 one irq per window", irq_cnt, 1);
    chk(irq_max_run == 1, "R10 irq width", irq_max_run, 1);
  endtask

  task automatic t_cont;
    logic [31:0] v;
    int cyc;
    int base;
    base = irq_cnt;
    wr(4'h4, cw(1, 1, 1, 1, 1, 0));
    for (int k = 1; k <= 3; k++) begin
      for (int i = 0; i < 2000; i++) begin
        if (irq_cnt >= base + k) break;
        @(negedge clk);
      end
      rd(4'hC, v);
      chk(v >= 48 && v <= 52, "R9 continuous window result", v, 50);
      rd(4'h4, v);
      chk(v[31] == 1'b1, "R9 busy stays high", v[31], 1);
    end
    wr(4'h4, cw(1, 1, 0, 1, 0, 0));
    wait_idle(cyc);
    repeat (2) @(negedge clk);
    chk(irq_cnt == base + 4, "R9 running window completes", irq_cnt - base, 4);
    repeat (600) @(negedge clk);
    chk(irq_cnt == base + 4, "R9 stops after clear", irq_cnt - base, 4);
    chk(irq_max_run == 1, "R10 pulses stay one cycle", irq_max_run, 1);
  endtask

  task automatic t_saturate;
    logic [31:0] v;
    int cyc;
    wr(4'h4, cw(99, 1, 0, 0, 1, 127), 1);
    wait_idle(cyc, 1);
    rd(4'hC, v, 1);
    chk(v == 32'h3FF, "R6 saturates at all-ones", v, 32'h3FF);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single;
    t_select;
    t_no_run;
    t_sel_change;
    t_abort;
    t_irq;
    t_cont;
    t_saturate;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule